// File: doc/BRIEF.md
# Oversampled Serial Receive Channel with Error Flags and Paced Flow Control

This block is the receive half of an asynchronous serial port. It watches a single serial input line and uses a 16x oversampling tick to find each start bit. It checks that start bit at its middle, then shifts in 7, 8 or 9 data bits, least significant first. After the data it takes an optional parity bit and one or two stop bits. The finished word goes into a one-entry holding register. Software reads that register through a read strobe and also sees a set of status flags: word waiting, parity error, framing error, overrun error, and a combined error flag that is the OR of the other three.

A flow-control output, `rts_n`, is active low. While a word is waiting it is held high, telling the far end to pause. When software takes the word, a programmable delay runs, and the line goes low again only when that delay expires. The delay is a 4-bit code `N` that gives 8·N bit times, so code 0 means no delay and code 15 means 120 bit times. For 9-bit multidrop links there is an address filter. When it is on, frames whose ninth bit is 0 are dropped until a frame whose ninth bit is 1 has arrived.

Top module: `uart_rx_core`

## Requirements
- R1: After reset every flag is 0, `rd_data` is 0 and `rts_n` is 0.
- R2: A frame is received with its data least significant bit first. `char_len` selects the data width: 0 gives 7 bits, 1 gives 8 bits, 2 gives 9 bits. The word is stored right-aligned in `rd_data` with zeros above it, and `buf_full` becomes 1. With `two_stop`=1 the receiver waits out a second stop bit and does not check its level.
- R3: A pulse on `rd_strobe` clears `buf_full` and all four error flags.
- R4: When `par_en`=1, one parity bit follows the data. `par_odd`=0 selects even parity and `par_odd`=1 selects odd parity. A mismatch sets `par_err` along with the stored word.
- R5: A low level at the middle of the first stop bit sets `frm_err`. The receiver then waits for the line to return high before it looks for the next start bit.
- R6: A frame that completes while `buf_full`=1 sets `ovr_err` and leaves the held word unchanged.
- R7: `sum_err` equals the OR of `par_err`, `frm_err` and `ovr_err`.
- R8: A 1 on `rx_init` empties the buffer, clears every flag and aborts any frame in progress. While `rx_init` is 0 it does nothing.
- R9: While `rx_en`=0 no frame is received and `buf_full` stays 0.
- R10: A low on the line that is gone by the middle of the start bit counts as noise. It produces no word.
- R11: With `addr_mode_en`=1 and 9-bit characters, frames whose bit 8 is 0 are discarded until a frame with bit 8 = 1 has been accepted. After that, all frames are accepted.
- R12: With `rts_en`=1, `rts_n` is high while a word is waiting. After a read it returns low once 8·`rts_dly` bit times have passed, or within two clocks when `rts_dly`=0. With `rts_en`=0, `rts_n` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_en | input | 1 | Reception enable |
| rx_init | input | 1 | Initialisation strobe that clears the buffer and flags |
| char_len | input | 2 | Data width code: 0 = 7 bits, 1 = 8 bits, 2 = 9 bits |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| two_stop | input | 1 | Frame carries two stop bits |
| addr_mode_en | input | 1 | Multidrop address filter enable |
| rts_en | input | 1 | Flow-control output enable |
| rts_dly | input | 4 | Release delay in steps of 8 bit times |
| rxd | input | 1 | Serial data input, idles high |
| rd_strobe | input | 1 | Read pulse that takes the word and clears the flags |
| rd_data | output | 9 | Received word |
| buf_full | output | 1 | A word is waiting |
| par_err | output | 1 | Parity mismatch |
| frm_err | output | 1 | First stop bit sampled low |
| ovr_err | output | 1 | A frame arrived while the buffer was full |
| sum_err | output | 1 | OR of the three error flags |
| rts_n | output | 1 | Flow control, active low |

## Verification
The bench targets the cases where a careless receiver goes wrong:
- **Overrun.** A receiver that overwrites the held word on overrun shows the second byte instead of the first.
- **Noise.** A short glitch on the idle line must not produce a word. A receiver that trusts the falling edge would deliver a spurious word of all ones.
- **Framing error.** After a framing error the stop bit stays low for its whole time. A receiver that goes straight back to hunting for a start bit would invent a frame from that low level.
- **Address filter.** The filter is checked both before and after the address frame. A filter that never opens, or that never closes, fails one of the two checks.
- **Flow-control delay.** The delay is probed just before and just after its expected end. A countdown in clocks instead of bit times, or one that starts at buffer-full instead of at the read, lands outside that window.

// File: rtl/uart_rx_pkg.sv
// Shared types and helpers for the serial receive channel.
package uart_rx_pkg;

    // Data width selector as presented on the char_len port.
    typedef enum logic [1:0] {
        LEN7 = 2'd0,
        LEN8 = 2'd1,
        LEN9 = 2'd2
    } len_e;

    // Frame sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP1,
        ST_STOP2,
        ST_WAIT_HI
    } rx_state_e;

    // Number of data bits for a width code (reserved code treated as 9).
    function automatic logic [3:0] data_bits(input len_e len);
        case (len)
            LEN7:    data_bits = 4'd7;
            LEN8:    data_bits = 4'd8;
            default: data_bits = 4'd9;
        endcase
    endfunction

endpackage

// File: rtl/rx_tick_gen.sv
// Oversampling tick generator.
// Emits a one-clock pulse every CLKS_PER_TICK clocks; 16 ticks make one bit.
// Assumes CLKS_PER_TICK >= 2.
module rx_tick_gen #(
    parameter int CLKS_PER_TICK = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int DW = $clog2(CLKS_PER_TICK);

    logic [DW-1:0] div_q;

    // Free-running divider, restarted by clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            div_q <= '0;
            tick  <= 1'b0;
        end else if (div_q == DW'(CLKS_PER_TICK - 1)) begin
            div_q <= '0;
            tick  <= 1'b1;
        end else begin
            div_q <= div_q + 1'b1;
            tick  <= 1'b0;
        end
    end
endmodule

// File: rtl/rx_frame_fsm.sv
// Frame sequencer: start-bit validation, data shift, parity and stop checks.
// Assumes rxd is already synchronised. A clear returns it to idle.
// Produces a one-clock done pulse with the word and its error bits.
module rx_frame_fsm
    import uart_rx_pkg::*;
#(
    parameter int OVS   = 16,
    parameter int WORD_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              tick,
    input  logic              rxd,
    input  len_e              len,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    output logic              done,
    output logic [WORD_W-1:0] word,
    output logic              perr,
    output logic              ferr
);
    localparam int TW = $clog2(OVS);
    localparam logic [TW-1:0] T_HALF = TW'(OVS / 2 - 1);
    localparam logic [TW-1:0] T_FULL = TW'(OVS - 1);

    rx_state_e         st_q;
    logic [TW-1:0]     tcnt_q;
    logic [3:0]        bidx_q;
    logic [WORD_W-1:0] sh_q;
    logic              pbit_q;
    logic [3:0]        nbits;
    logic              at_mid;

    assign nbits  = data_bits(len);
    assign at_mid = tick && (tcnt_q == T_FULL);

    // Sequencer: counts ticks within each bit and samples at mid-bit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            st_q   <= ST_IDLE;
            tcnt_q <= '0;
            bidx_q <= '0;
            sh_q   <= '0;
            pbit_q <= 1'b0;
            done   <= 1'b0;
            word   <= '0;
            perr   <= 1'b0;
            ferr   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick && st_q != ST_IDLE && st_q != ST_WAIT_HI)
                tcnt_q <= (tcnt_q == T_FULL) ? '0 : tcnt_q + 1'b1;
            case (st_q)
                ST_IDLE: begin
                    if (!rxd) begin
                        st_q   <= ST_START;
                        tcnt_q <= '0;
                    end
                end
                ST_START: begin
                    if (tick && tcnt_q == T_HALF) begin
                        tcnt_q <= '0;
                        if (!rxd) begin
                            st_q   <= ST_DATA;
                            bidx_q <= '0;
                            sh_q   <= '0;
                        end else begin
                            st_q <= ST_IDLE;
                        end
                    end
                end
                ST_DATA: begin
                    if (at_mid) begin
                        sh_q[bidx_q] <= rxd;
                        if (bidx_q == nbits - 4'd1)
                            st_q <= par_en ? ST_PAR : ST_STOP1;
                        else
                            bidx_q <= bidx_q + 4'd1;
                    end
                end
                ST_PAR: begin
                    if (at_mid) begin
                        pbit_q <= rxd;
                        st_q   <= ST_STOP1;
                    end
                end
                ST_STOP1: begin
                    if (at_mid) begin
                        done <= 1'b1;
                        word <= sh_q;
                        perr <= par_en && ((^sh_q) ^ pbit_q ^ par_odd);
                        ferr <= !rxd;
                        if (!rxd)          st_q <= ST_WAIT_HI;
                        else if (two_stop) st_q <= ST_STOP2;
                        else               st_q <= ST_IDLE;
                    end
                end
                ST_STOP2: begin
                    if (at_mid) st_q <= rxd ? ST_IDLE : ST_WAIT_HI;
                end
                ST_WAIT_HI: begin
                    if (rxd) st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rx_word_buf.sv
// One-word receive holding register with status flags and address filter.
// Assumes done is a single-cycle pulse. A read in the same cycle as a
// completing frame frees the slot first, so that frame is loaded.
module rx_word_buf
    import uart_rx_pkg::*;
#(
    parameter int WORD_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic              rx_en,
    input  logic              addr_mode_en,
    input  len_e              len,
    input  logic              done,
    input  logic [WORD_W-1:0] word,
    input  logic              perr,
    input  logic              ferr,
    input  logic              rd,
    output logic [WORD_W-1:0] data_q,
    output logic              full_q,
    output logic              par_q,
    output logic              frm_q,
    output logic              ovr_q,
    output logic              sum_q
);
    logic addr_mode;
    logic matched_q;
    logic accept;

    assign addr_mode = addr_mode_en && (len == LEN9);
    assign accept    = done && rx_en && (!addr_mode || matched_q || word[WORD_W-1]);

    // Address filter: opens on the first frame whose top bit is set.
    always_ff @(posedge clk) begin
        if (!rst_n || init || !addr_mode)
            matched_q <= 1'b0;
        else if (accept && word[WORD_W-1])
            matched_q <= 1'b1;
    end

    // Holding register and flags: read clears, accepted frame loads or overruns.
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            data_q <= '0;
            full_q <= 1'b0;
            par_q  <= 1'b0;
            frm_q  <= 1'b0;
            ovr_q  <= 1'b0;
            sum_q  <= 1'b0;
        end else begin
            if (rd) begin
                full_q <= 1'b0;
                par_q  <= 1'b0;
                frm_q  <= 1'b0;
                ovr_q  <= 1'b0;
                sum_q  <= 1'b0;
            end
            if (accept) begin
                if (full_q && !rd) begin
                    ovr_q <= 1'b1;
                    sum_q <= 1'b1;
                end else begin
                    data_q <= word;
                    full_q <= 1'b1;
                    par_q  <= perr;
                    frm_q  <= ferr;
                    sum_q  <= perr | ferr;
                end
            end
        end
    end
endmodule

// File: rtl/rts_delay_ctrl.sv
// Flow-control pacing: holds rts_n high while a word waits. After a read it
// counts code * STEP_BITS bit times in oversampling ticks, then releases.
// Assumes tick is the same oversampling tick used by the receiver.
module rts_delay_ctrl #(
    parameter int OVS       = 16,
    parameter int STEP_BITS = 8,
    parameter int DLY_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             tick,
    input  logic             rts_en,
    input  logic [DLY_W-1:0] code,
    input  logic             full,
    input  logic             rd,
    output logic             rts_n
);
    localparam int STEP_TICKS = STEP_BITS * OVS;
    localparam int MAX_TICKS  = ((1 << DLY_W) - 1) * STEP_TICKS;
    localparam int CW         = $clog2(MAX_TICKS + 1);

    logic          hold_q;
    logic [CW-1:0] cnt_q;

    // Hold state and countdown of the release delay.
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            hold_q <= 1'b0;
            cnt_q  <= '0;
        end else if (full && rd) begin
            hold_q <= (code != '0);
            cnt_q  <= CW'(code) * CW'(STEP_TICKS);
        end else if (full) begin
            hold_q <= 1'b1;
            cnt_q  <= '0;
        end else if (hold_q && tick) begin
            if (cnt_q <= CW'(1)) begin
                hold_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // Registered output, gated by the enable.
    always_ff @(posedge clk) begin
        if (!rst_n || init) rts_n <= 1'b0;
        else                rts_n <= rts_en && (hold_q || full);
    end
endmodule

// File: rtl/uart_rx_core.sv
// Serial receive channel top: input synchroniser, tick generator, frame
// sequencer, holding register and flow-control pacing.
// Assumes a clock of 16 * CLKS_PER_TICK times the bit rate and an idle-high line.
module uart_rx_core
    import uart_rx_pkg::*;
#(
    parameter int CLKS_PER_TICK = 4,
    parameter int OVS           = 16,
    parameter int RTS_STEP_BITS = 8,
    parameter int DLY_W         = 4,
    parameter int WORD_W        = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              rx_init,
    input  logic [1:0]        char_len,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    input  logic              addr_mode_en,
    input  logic              rts_en,
    input  logic [DLY_W-1:0]  rts_dly,
    input  logic              rxd,
    input  logic              rd_strobe,
    output logic [WORD_W-1:0] rd_data,
    output logic              buf_full,
    output logic              par_err,
    output logic              frm_err,
    output logic              ovr_err,
    output logic              sum_err,
    output logic              rts_n
);
    logic [1:0]        sync_q;
    logic              tick;
    logic              fr_done;
    logic [WORD_W-1:0] fr_word;
    logic              fr_perr;
    logic              fr_ferr;
    len_e              len;

    assign len = len_e'(char_len);

    // Two-flop synchroniser on the serial input, idles high.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rxd};
    end

    rx_tick_gen #(.CLKS_PER_TICK(CLKS_PER_TICK)) tick_i (
        .clk(clk), .rst_n(rst_n), .clr(rx_init), .tick(tick)
    );

    rx_frame_fsm #(.OVS(OVS), .WORD_W(WORD_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .clr(rx_init || !rx_en), .tick(tick),
        .rxd(sync_q[1]), .len(len), .par_en(par_en), .par_odd(par_odd),
        .two_stop(two_stop), .done(fr_done), .word(fr_word),
        .perr(fr_perr), .ferr(fr_ferr)
    );

    rx_word_buf #(.WORD_W(WORD_W)) buf_i (
        .clk(clk), .rst_n(rst_n), .init(rx_init), .rx_en(rx_en),
        .addr_mode_en(addr_mode_en), .len(len), .done(fr_done),
        .word(fr_word), .perr(fr_perr), .ferr(fr_ferr), .rd(rd_strobe),
        .data_q(rd_data), .full_q(buf_full), .par_q(par_err),
        .frm_q(frm_err), .ovr_q(ovr_err), .sum_q(sum_err)
    );

    rts_delay_ctrl #(.OVS(OVS), .STEP_BITS(RTS_STEP_BITS), .DLY_W(DLY_W)) rts_i (
        .clk(clk), .rst_n(rst_n), .init(rx_init), .tick(tick),
        .rts_en(rts_en), .code(rts_dly), .full(buf_full),
        .rd(rd_strobe), .rts_n(rts_n)
    );
endmodule

// File: rtl/uart_rx_sva.sv
// Property checker for the serial receive channel, bound to the top module.
module uart_rx_sva #(
    parameter int WORD_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_en,
    input logic              rx_init,
    input logic              rd_strobe,
    input logic              rts_en,
    input logic [WORD_W-1:0] rd_data,
    input logic              buf_full,
    input logic              par_err,
    input logic              frm_err,
    input logic              ovr_err,
    input logic              sum_err,
    input logic              rts_n
);
    assert_sum_matches_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sum_err == (par_err | frm_err | ovr_err));

    assert_err_needs_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (par_err | frm_err | ovr_err) |-> buf_full);

    assert_read_clears_ovr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> !ovr_err);

    assert_init_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_init |=> (!buf_full && !par_err && !frm_err && !ovr_err));

    assert_held_word_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_full && !rd_strobe && !rx_init) |=> (buf_full && $stable(rd_data)));

    assert_no_rx_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !buf_full) |=> !buf_full);

    assert_rts_high_when_full_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rts_en && buf_full && !rx_init) |=> rts_n);

    assert_rts_off_when_disabled_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rts_en |=> !rts_n);
endmodule

bind uart_rx_core uart_rx_sva #(.WORD_W(WORD_W)) sva_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_init(rx_init),
    .rd_strobe(rd_strobe), .rts_en(rts_en), .rd_data(rd_data),
    .buf_full(buf_full), .par_err(par_err), .frm_err(frm_err),
    .ovr_err(ovr_err), .sum_err(sum_err), .rts_n(rts_n)
);

// File: tb/uart_rx_core_tb_top.sv
// Directed bench: one task per scenario, each checking its own results.
module uart_rx_core_tb_top;
    localparam int BIT_CLKS = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0, rx_init = 1'b0;
    logic [1:0] char_len = 2'd1;
    logic       par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0;
    logic       addr_mode_en = 1'b0, rts_en = 1'b0;
    logic [3:0] rts_dly = 4'd0;
    logic       rxd = 1'b1, rd_strobe = 1'b0;
    logic [8:0] rd_data;
    logic       buf_full, par_err, frm_err, ovr_err, sum_err, rts_n;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    uart_rx_core dut_i (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_init(rx_init),
        .char_len(char_len), .par_en(par_en), .par_odd(par_odd),
        .two_stop(two_stop), .addr_mode_en(addr_mode_en), .rts_en(rts_en),
        .rts_dly(rts_dly), .rxd(rxd), .rd_strobe(rd_strobe),
        .rd_data(rd_data), .buf_full(buf_full), .par_err(par_err),
        .frm_err(frm_err), .ovr_err(ovr_err), .sum_err(sum_err), .rts_n(rts_n)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive_bit(input logic b);
        rxd = b;
        idle(BIT_CLKS);
    endtask

    // Sends one frame; pbit is used only when has_par is set.
    task automatic send(input logic [8:0] d, input int nbits, input bit has_par,
                        input logic pbit, input bit stop_low, input int nstop);
        drive_bit(1'b0);
        for (int i = 0; i < nbits; i++) drive_bit(d[i]);
        if (has_par) drive_bit(pbit);
        drive_bit(!stop_low);
        for (int i = 1; i < nstop; i++) drive_bit(1'b1);
        rxd = 1'b1;
        idle(BIT_CLKS);
    endtask

    function automatic logic even_pbit(input logic [8:0] d, input int nbits);
        logic p = 1'b0;
        for (int i = 0; i < nbits; i++) p ^= d[i];
        return p;
    endfunction

    task automatic do_read();
        @(negedge clk); rd_strobe = 1'b1;
        @(negedge clk); rd_strobe = 1'b0;
        idle(2);
    endtask

    task automatic do_init();
        @(negedge clk); rx_init = 1'b1;
        @(negedge clk); rx_init = 1'b0;
        idle(2);
    endtask

    task automatic flags(input string req, input int f, input int p, input int fr, input int o, input int s);
        chk(req, "buf_full", int'(buf_full), f);
        chk(req, "par_err", int'(par_err), p);
        chk(req, "frm_err", int'(frm_err), fr);
        chk(req, "ovr_err", int'(ovr_err), o);
        chk(req, "sum_err", int'(sum_err), s);
    endtask

    task automatic t_reset();
        flags("R1", 0, 0, 0, 0, 0);
        chk("R1", "rd_data", int'(rd_data), 0);
        chk("R1", "rts_n", int'(rts_n), 0);
    endtask

    task automatic t_basic8();
        char_len = 2'd1;
        send(9'h0A5, 8, 0, 1'b0, 0, 1);
        chk("R2", "8-bit data", int'(rd_data), 'hA5);
        flags("R2", 1, 0, 0, 0, 0);
        do_read();
        flags("R3", 0, 0, 0, 0, 0);
        two_stop = 1'b1;
        send(9'h03C, 8, 0, 1'b0, 0, 2);
        chk("R2", "two-stop data", int'(rd_data), 'h3C);
        two_stop = 1'b0;
        do_read();
    endtask

    task automatic t_parity();
        char_len = 2'd0; par_en = 1'b1; par_odd = 1'b0;
        send(9'h05B, 7, 1, even_pbit(9'h05B, 7), 0, 1);
        chk("R2", "7-bit data", int'(rd_data), 'h5B);
        flags("R4", 1, 0, 0, 0, 0);
        do_read();
        send(9'h05B, 7, 1, !even_pbit(9'h05B, 7), 0, 1);
        flags("R4", 1, 1, 0, 0, 1);
        do_read();
        par_odd = 1'b1; char_len = 2'd1;
        send(9'h0C3, 8, 1, !even_pbit(9'h0C3, 8), 0, 1);
        chk("R4", "odd ok par_err", int'(par_err), 0);
        do_read();
        send(9'h0C3, 8, 1, even_pbit(9'h0C3, 8), 0, 1);
        chk("R7", "odd bad sum_err", int'(sum_err), 1);
        do_read();
        par_en = 1'b0; par_odd = 1'b0;
    endtask

    task automatic t_framing();
        char_len = 2'd1;
        send(9'h081, 8, 0, 1'b0, 1, 1);
        chk("R5", "data", int'(rd_data), 'h81);
        flags("R5", 1, 0, 1, 0, 1);
        do_read();
        idle(4 * BIT_CLKS);
        chk("R5", "no phantom frame", int'(buf_full), 0);
    endtask

    task automatic t_overrun();
        send(9'h011, 8, 0, 1'b0, 0, 1);
        send(9'h022, 8, 0, 1'b0, 0, 1);
        chk("R6", "old data kept", int'(rd_data), 'h11);
        flags("R6", 1, 0, 0, 1, 1);
        do_read();
        flags("R3", 0, 0, 0, 0, 0);
    endtask

    task automatic t_init();
        send(9'h0F0, 8, 0, 1'b0, 1, 1);
        chk("R8", "pre-init frm_err", int'(frm_err), 1);
        do_init();
        flags("R8", 0, 0, 0, 0, 0);
        chk("R8", "rd_data", int'(rd_data), 0);
    endtask

    task automatic t_disabled();
        rx_en = 1'b0;
        send(9'h066, 8, 0, 1'b0, 0, 1);
        chk("R9", "no word while off", int'(buf_full), 0);
        rx_en = 1'b1;
        idle(4);
    endtask

    task automatic t_noise();
        rxd = 1'b0; idle(16);
        rxd = 1'b1; idle(4 * BIT_CLKS);
        chk("R10", "glitch ignored", int'(buf_full), 0);
        send(9'h05A, 8, 0, 1'b0, 0, 1);
        chk("R10", "frame after glitch", int'(rd_data), 'h5A);
        do_read();
    endtask

    task automatic t_addr();
        char_len = 2'd2; addr_mode_en = 1'b1;
        send(9'h055, 9, 0, 1'b0, 0, 1);
        chk("R11", "data frame dropped", int'(buf_full), 0);
        send(9'h1A3, 9, 0, 1'b0, 0, 1);
        chk("R11", "address frame", int'(rd_data), 'h1A3);
        do_read();
        send(9'h042, 9, 0, 1'b0, 0, 1);
        chk("R11", "data after address", int'(rd_data), 'h042);
        chk("R11", "full after address", int'(buf_full), 1);
        do_read();
        addr_mode_en = 1'b0;
        send(9'h013, 9, 0, 1'b0, 0, 1);
        chk("R2", "9-bit data no filter", int'(rd_data), 'h013);
        do_read();
        char_len = 2'd1;
    endtask

    task automatic t_rts();
        rts_en = 1'b1; rts_dly = 4'd1;
        send(9'h077, 8, 0, 1'b0, 0, 1);
        chk("R12", "high while full", int'(rts_n), 1);
        do_read();
        idle(400);
        chk("R12", "still held mid-delay", int'(rts_n), 1);
        idle(200);
        chk("R12", "released after 8 bits", int'(rts_n), 0);
        rts_dly = 4'd0;
        send(9'h078, 8, 0, 1'b0, 0, 1);
        chk("R12", "high while full code0", int'(rts_n), 1);
        do_read();
        chk("R12", "immediate release", int'(rts_n), 0);
        rts_en = 1'b0;
        send(9'h079, 8, 0, 1'b0, 0, 1);
        chk("R12", "disabled stays low", int'(rts_n), 0);
        do_read();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        idle(5);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        rx_en = 1'b1;
        idle(BIT_CLKS);
        t_basic8();
        t_parity();
        t_framing();
        t_overrun();
        t_init();
        t_disabled();
        t_noise();
        t_addr();
        t_rts();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule